// File: doc/BRIEF.md
# Row Hit Compactor With Token Chain

This block compacts the hits of one pixel row into a short list. For every cell of the row it takes a 3-bit digitized value; a value of zero means the cell saw nothing. A start pulse snapshots the whole row and sends a token into the cell chain at cell 0. Cells holding zero let the token pass in the same cycle. The first cell still holding an unserved hit claims the token, and for that cycle it drives its column address and value onto a shared row bus.

On each cycle in which a cell holds the token, the bus word moves into the newest slot of a shift-register chain of row buffers. Each slot carries a valid bit next to the address and value. A counter records how many words were captured. When no unserved hit is left, the token leaves the last cell, the scan ends and a done flag rises. If a row holds more hits than there are buffer slots, the oldest words fall off the far end of the chain and a sticky overflow flag is set. The counter still counts every hit.

Downstream logic waits for done and then reads the buffer slots, the count and the overflow flag.

Top module: `row_hit_compactor`

## Requirements
- R1: While reset is held and after its release, busy, done, overflow, hit_count and every buf_valid bit are 0.
- R2: A start pulse while idle, or while done is high, begins a scan, so busy is 1 after that edge. A start pulse while busy is ignored and the scan result is unchanged.
- R3: Each cell with a nonzero value is captured exactly once, one per cycle, in ascending address order. Cells with value 000 are never captured.
- R4: A captured word enters slot 0, and older words move one slot up. Slot s is buf_valid[s], buf_addr[s*9 +: 9] (cell address 0 to 511) and buf_data[s*3 +: 3] (the cell value).
- R5: hit_count equals the number of hits captured in the current scan. It rises by 1 on each capture and is cleared when a scan starts.
- R6: For a row with K hits, done rises K+1 clock edges after the edge that accepts start, and busy falls on that same edge. Done then stays high until the next accepted start.
- R7: With more than DEPTH hits, the oldest words are dropped, the buffer holds the newest DEPTH hits, and overflow is set and stays set until the next accepted start. With exactly DEPTH hits, overflow stays 0.
- R8: A hit at address 0 shows valid 1 and address 0. An empty slot shows valid 0. Valid slots are always contiguous from slot 0.
- R9: The row is sampled on the edge that accepts start. Changes on pix_data during the scan have no effect on the result.
- R10: A row with no hits gives done one edge after start is accepted, with hit_count 0 and no valid slots.
- R11: An accepted start clears the buffers, hit_count, overflow and done on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Token clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Snapshot the row and inject the token |
| pix_data | input | NUM_CELLS*DATA_W | Cell values, cell i at bits i*DATA_W +: DATA_W |
| busy | output | 1 | Token is inside the chain |
| done | output | 1 | Token has left the last cell |
| overflow | output | 1 | Sticky: at least one word was dropped |
| hit_count | output | $clog2(NUM_CELLS+1) | Hits captured in this scan |
| buf_valid | output | DEPTH | Valid bit per buffer slot |
| buf_addr | output | DEPTH*ADDR_W | Cell address per slot |
| buf_data | output | DEPTH*DATA_W | Cell value per slot |

## Verification
Once the chain is full, a single capture edge must do two things: push the newest word into slot 0 and drop the oldest word off slot DEPTH-1, which also sets overflow. The bench provokes this with rows of 18 and 25 hits against the default depth of 18. A scoreboard monitor compares the newest slot on every count step. At the end of each scan the bench requires that the surviving slots are exactly the last DEPTH expected words, newest first, and that overflow is set only for the 25-hit row.

// File: rtl/rhc_pkg.sv
package rhc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_t;
endpackage

// File: rtl/rhc_token_chain.sv
module rhc_token_chain #(
  parameter int NUM_CELLS = 512,
  parameter int DATA_W    = 3,
  parameter int ADDR_W    = 9
) (
  input  logic                          active,
  input  logic [NUM_CELLS-1:0]          pending,
  input  logic [NUM_CELLS*DATA_W-1:0]   row,
  output logic [NUM_CELLS-1:0]          grant,
  output logic                          token_out,
  output logic                          bus_en,
  output logic [ADDR_W-1:0]             bus_addr,
  output logic [DATA_W-1:0]             bus_data
);
  logic [NUM_CELLS:0] tok;

  // token ripples through cells that have nothing left to send
  always_comb begin
    tok[0] = active;
    for (int i = 0; i < NUM_CELLS; i++) begin
      grant[i]  = tok[i] & pending[i];
      tok[i+1]  = tok[i] & ~pending[i];
    end
  end

  assign token_out = tok[NUM_CELLS];
  assign bus_en    = |grant;

  // shared row bus: wired-OR of the single enabled cell
  always_comb begin
    bus_addr = '0;
    bus_data = '0;
    for (int i = 0; i < NUM_CELLS; i++) begin
      if (grant[i]) begin
        bus_addr = bus_addr | ADDR_W'(i);
        bus_data = bus_data | row[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/rhc_row_buffer.sv
module rhc_row_buffer #(
  parameter int DEPTH  = 18,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     shift,
  input  logic [ADDR_W-1:0]        in_addr,
  input  logic [DATA_W-1:0]        in_data,
  output logic [DEPTH-1:0]         valid,
  output logic [DEPTH*ADDR_W-1:0]  addr_flat,
  output logic [DEPTH*DATA_W-1:0]  data_flat,
  output logic                     lost
);
  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid_q <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (shift) begin
      valid_q <= {valid_q[DEPTH-2:0], 1'b1};
      addr_q  <= {addr_q[DEPTH-2:0], in_addr};
      data_q  <= {data_q[DEPTH-2:0], in_data};
    end
  end

  assign lost      = shift & valid_q[DEPTH-1];
  assign valid     = valid_q;
  assign addr_flat = addr_q;
  assign data_flat = data_q;
endmodule

// File: rtl/row_hit_compactor.sv
module row_hit_compactor #(
  parameter int NUM_CELLS = 512,
  parameter int DATA_W    = 3,
  parameter int DEPTH     = 18,
  localparam int ADDR_W   = $clog2(NUM_CELLS),
  localparam int CNT_W    = $clog2(NUM_CELLS + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [NUM_CELLS*DATA_W-1:0]  pix_data,
  output logic                         busy,
  output logic                         done,
  output logic                         overflow,
  output logic [CNT_W-1:0]             hit_count,
  output logic [DEPTH-1:0]             buf_valid,
  output logic [DEPTH*ADDR_W-1:0]      buf_addr,
  output logic [DEPTH*DATA_W-1:0]      buf_data
);
  import rhc_pkg::*;

  scan_state_t                 state_q;
  logic [NUM_CELLS-1:0]        pending_q;
  logic [NUM_CELLS*DATA_W-1:0] row_q;
  logic [NUM_CELLS-1:0]        hit_mask;
  logic [CNT_W-1:0]            count_q;
  logic                        done_q;
  logic                        ovf_q;

  logic [NUM_CELLS-1:0] grant;
  logic                 token_out;
  logic                 bus_en;
  logic [ADDR_W-1:0]    bus_addr;
  logic [DATA_W-1:0]    bus_data;
  logic                 lost;
  logic                 scanning;
  logic                 accept;

  generate
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_hit
      assign hit_mask[c] = |pix_data[c*DATA_W +: DATA_W];
    end
  endgenerate

  assign scanning = (state_q == ST_SCAN);
  assign accept   = start & ~scanning;

  rhc_token_chain #(
    .NUM_CELLS(NUM_CELLS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_chain (
    .active   (scanning),
    .pending  (pending_q),
    .row      (row_q),
    .grant    (grant),
    .token_out(token_out),
    .bus_en   (bus_en),
    .bus_addr (bus_addr),
    .bus_data (bus_data)
  );

  rhc_row_buffer #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .shift    (scanning & bus_en),
    .in_addr  (bus_addr),
    .in_data  (bus_data),
    .valid    (buf_valid),
    .addr_flat(buf_addr),
    .data_flat(buf_data),
    .lost     (lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pending_q <= '0;
      row_q     <= '0;
      count_q   <= '0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (accept) begin
      state_q   <= ST_SCAN;
      row_q     <= pix_data;
      pending_q <= hit_mask;
      count_q   <= '0;
      done_q    <= 1'b0;
      ovf_q     <= 1'b0;
    end else if (scanning) begin
      if (token_out) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end else begin
        pending_q <= pending_q & ~grant;
        count_q   <= count_q + CNT_W'(1);
        if (lost) ovf_q <= 1'b1;
      end
    end
  end

  assign busy      = scanning;
  assign done      = done_q;
  assign overflow  = ovf_q;
  assign hit_count = count_q;
endmodule

// File: rtl/rhc_checker.sv
module rhc_checker #(
  parameter int NUM_CELLS = 512,
  parameter int DEPTH     = 18,
  parameter int CNT_W     = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic                 overflow,
  input logic [CNT_W-1:0]     hit_count,
  input logic [DEPTH-1:0]     buf_valid,
  input logic [NUM_CELLS-1:0] grant,
  input logic                 token_out
);
  assert_single_owner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !token_out) |=> busy);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      ((hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + CNT_W'(1))));

  assert_newest_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (hit_count == $past(hit_count) + CNT_W'(1)) |-> buf_valid[0]);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(overflow) && !$past(start)) |-> overflow);

  assert_overflow_needs_full_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(buf_valid[DEPTH-1]));

  generate
    for (genvar s = 0; s < DEPTH - 1; s++) begin : g_pack
      assert_valid_packed_R8: assert property (@(posedge clk) disable iff (rst)
        buf_valid[s+1] |-> buf_valid[s]);
    end
  endgenerate
endmodule

bind row_hit_compactor rhc_checker #(
  .NUM_CELLS(NUM_CELLS), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .overflow (overflow),
  .hit_count(hit_count),
  .buf_valid(buf_valid),
  .grant    (grant),
  .token_out(token_out)
);

// File: tb/row_hit_compactor_test.sv
module row_hit_compactor_test;
  localparam int NUM   = 512;
  localparam int DW    = 3;
  localparam int AW    = 9;
  localparam int DEPTH = 18;
  localparam int CW    = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [NUM*DW-1:0] pix_data = '0;
  logic              busy, done, overflow;
  logic [CW-1:0]     hit_count;
  logic [DEPTH-1:0]  buf_valid;
  logic [DEPTH*AW-1:0] buf_addr;
  logic [DEPTH*DW-1:0] buf_data;

  row_hit_compactor #(.NUM_CELLS(NUM), .DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .start(start), .pix_data(pix_data),
    .busy(busy), .done(done), .overflow(overflow), .hit_count(hit_count),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_data(buf_data)
  );

  always #2 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_addr_q[$];
  int exp_data_q[$];
  int prev_count = 0;
  int wd_cycles = 0;
  logic [NUM*DW-1:0] row_v;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: every count step must show the next expected word in slot 0
  always @(negedge clk) begin
    if (!rst) begin
      if (int'(hit_count) == prev_count + 1) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R3", "unexpected capture addr", int'(buf_addr[AW-1:0]), -1);
        end else begin
          int ea, ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          check(buf_valid[0] == 1'b1, "R3", "slot0 valid", int'(buf_valid[0]), 1);
          check(int'(buf_addr[AW-1:0]) == ea, "R3", "slot0 addr", int'(buf_addr[AW-1:0]), ea);
          check(int'(buf_data[DW-1:0]) == ed, "R3", "slot0 data", int'(buf_data[DW-1:0]), ed);
        end
      end
      prev_count = int'(hit_count);
    end
  end

  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd_cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic clear_row();
    row_v = '0;
  endtask

  task automatic set_cell(input int c, input int v);
    row_v[c*DW +: DW] = DW'(v);
  endtask

  // drive one scan of row_v; extra_at>0 pulses start mid-scan, scramble alters pix after start
  task automatic run_scan(input string name, input int extra_at, input bit scramble);
    int la[$];
    int ld[$];
    int k, cyc, keep, idx;
    for (int c = 0; c < NUM; c++) begin
      if (row_v[c*DW +: DW] != '0) begin
        la.push_back(c);
        ld.push_back(int'(row_v[c*DW +: DW]));
        exp_addr_q.push_back(c);
        exp_data_q.push_back(int'(row_v[c*DW +: DW]));
      end
    end
    k = la.size();
    @(negedge clk);
    pix_data = row_v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy == 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
    check(done == 1'b0 && overflow == 1'b0, "R11", {name, " flags cleared"},
          int'({done, overflow}), 0);
    if (scramble) begin
      for (int c = 0; c < NUM; c++) pix_data[c*DW +: DW] = 3'b110;
    end
    while (!done && cyc < 2000) begin
      if (extra_at > 0 && cyc == extra_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == k + 2, "R6", {name, " done timing"}, cyc, k + 2);
    check(busy == 1'b0, "R6", {name, " busy low at done"}, int'(busy), 0);
    check(int'(hit_count) == k, "R5", {name, " hit count"}, int'(hit_count), k);
    check(overflow == (k > DEPTH), "R7", {name, " overflow"}, int'(overflow), int'(k > DEPTH));
    check(exp_addr_q.size() == 0, "R3", {name, " words left uncaptured"}, exp_addr_q.size(), 0);
    exp_addr_q.delete();
    exp_data_q.delete();
    keep = (k < DEPTH) ? k : DEPTH;
    for (int s = 0; s < DEPTH; s++) begin
      if (s < keep) begin
        idx = k - 1 - s;
        check(buf_valid[s] == 1'b1 &&
              int'(buf_addr[s*AW +: AW]) == la[idx] &&
              int'(buf_data[s*DW +: DW]) == ld[idx],
              "R4", {name, " slot addr"}, int'(buf_addr[s*AW +: AW]), la[idx]);
      end else begin
        check(buf_valid[s] == 1'b0, "R8", {name, " empty slot valid"}, int'(buf_valid[s]), 0);
      end
    end
    repeat (2) @(negedge clk);
    check(done == 1'b1, "R6", {name, " done held"}, int'(done), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(busy == 0 && done == 0 && overflow == 0, "R1", "flags in reset",
          int'({busy, done, overflow}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(hit_count == '0, "R1", "count after reset", int'(hit_count), 0);
    check(buf_valid == '0, "R1", "valid after reset", int'(buf_valid), 0);

    // R10: empty row
    clear_row();
    run_scan("R10 empty", 0, 1'b0);

    // R3 / R8: sparse row including address 0 and 511
    clear_row();
    set_cell(0, 5); set_cell(3, 1); set_cell(200, 4); set_cell(511, 7);
    run_scan("R3 sparse", 0, 1'b0);
    check(buf_valid[3] == 1'b1 && buf_addr[3*AW +: AW] == '0, "R8", "address 0 hit kept",
          int'(buf_addr[3*AW +: AW]), 0);

    // R2: adjacent hits with a start pulse during the scan
    clear_row();
    for (int i = 0; i < 5; i++) set_cell(10 + i, i + 1);
    run_scan("R2 restart ignored", 3, 1'b0);

    // R9: pixel inputs change during scan
    clear_row();
    set_cell(100, 2); set_cell(300, 6);
    run_scan("R9 snapshot", 0, 1'b1);

    // R7 boundary: exactly DEPTH hits
    clear_row();
    for (int i = 0; i < DEPTH; i++) set_cell(20 + i, (i % 7) + 1);
    run_scan("R7 full", 0, 1'b0);

    // R7: more hits than DEPTH, oldest dropped on the same edge as the newest enters
    clear_row();
    for (int i = 0; i < 25; i++) set_cell(2 * i + 1, (i % 7) + 1);
    run_scan("R7 overflow", 0, 1'b0);

    // R11: next scan clears the overflow and old words
    clear_row();
    set_cell(0, 3);
    run_scan("R11 clear", 0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule